// File: doc/BRIEF.md
# TDM Timeslot Host Access Unit

This unit gives a host processor byte-level access to a framed serial bus with twelve 8-bit timeslots per frame and two data lines: a downstream line (DD) and an upstream line (DU). It has four access channels arranged as two pairs. Each channel has a timeslot number, a line select, an input enable and an output enable. A channel can capture a slot from one line, drive a slot onto the other line, or do both. Looping, shifting, switching and monitoring are all built from these operations. When the swap bit of a pair is set, what one channel captures is stored in its partner. This lets a byte taken from one slot be replayed in a different slot.

Bit timing comes from a one-cycle bit strobe. A frame-start flag given together with a strobe marks bit 0 of slot 0. Outputs behave like open drain: an undriven bit is 1, and channels that drive the same line combine by wired-AND. The host can watch one channel's slot. Its passage raises a synchronous-transfer flag, which opens the window in which the host may safely touch the data. If that slot comes round again while the flag is still set, an overflow flag is raised.

Top module: `tdm_slot_access`

## Requirements
- R1: After reset, both line outputs are 1, the interrupt output is low, the data registers read 0xFF, and the configuration, swap, status and watch registers read 0.
- R2: Bit positions are defined as follows. A strobe with the frame flag set makes the following bit period bit 0 of slot 0. Each later strobe advances one bit, MSB first, with 8 bits per slot and 12 slots per frame. A strobe ends the current bit period and samples the line for it. Until the first frame flag, nothing is driven or captured.
- R3: In the configuration register, bit 4 selects the lines. With 0, the channel drives DD and captures from DU. With 1, it drives DU and captures from DD.
- R4: A channel captures only when its input enable (configuration bit 5) is set. It drives only when its output enable (bit 6) is set, and only during its slot (bits 3:0). An undriven bit is 1, and several channels on one line and slot combine by AND.
- R5: In looping, the byte that slot a carries on one line is driven in slot a on the other line one frame later.
- R6: Shifting through a swapped pair, from slot a to slot b, shows the byte in the same frame when b is at least a+2. Otherwise it shows the byte in the next frame. Each channel loads its output byte from its data register at the start of its slot.
- R7: With a pair's swap bit set (register 8, bit 0 for channels 0/1, bit 1 for channels 2/3), a completed capture is stored in the partner channel's data register and not in the channel's own register. With the bit clear, it is stored in the channel's own register.
- R8: A channel with only its input enable set captures its slot without driving any line, and the host can read the byte back.
- R9: If the watch register (address 10) has bit 2 set, the end of the last bit of the watched channel's slot (bits 1:0) sets the transfer flag (status bit 0, address 9), and the interrupt output rises. Writing 1 to status bit 0 clears the flag.
- R10: The overflow flag (status bit 1) is set when the watched slot ends while the transfer flag is still set. Writing 1 to status bit 1 clears it. An acknowledged window gives no overflow.
- R11: If a capture into a data register and a host write to that register fall on the same edge, the captured byte is kept.
- R12: The register map is as follows. Addresses 0 to 3 are the data registers. Addresses 4 to 7 are the configuration registers of channels 0 to 3. Address 8 is swap, 9 is status, and 10 is watch. Reads return the register content, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit strobe, one cycle per serial bit |
| fsc_i | input | 1 | Frame start, valid with a strobe |
| dd_i | input | 1 | Downstream line as seen on the bus |
| du_i | input | 1 | Upstream line as seen on the bus |
| dd_o | output | 1 | Downstream drive, 1 means released |
| du_o | output | 1 | Upstream drive, 1 means released |
| wr_i | input | 1 | Host write strobe |
| addr_i | input | 4 | Host register address |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data for addr_i |
| irq_o | output | 1 | Transfer or overflow flag pending |

## Verification
A bus capture and a host write can land on the same clock edge and target the same data register. The bench arms a write to that register so that it goes out in exactly the strobe cycle that ends the slot's last bit, then reads the register back and expects the bus byte. A second collision is the watched slot's event arriving on the edge where the host clears the transfer flag. This is judged by the cycle-by-cycle reference model, which sees the flag as still pending and expects the overflow flag to be set.

// File: rtl/tdm_access_pkg.sv
package tdm_access_pkg;
  localparam int unsigned CFG_DPS  = 4;
  localparam int unsigned CFG_EIN  = 5;
  localparam int unsigned CFG_EOUT = 6;
  localparam int unsigned ST_STI   = 0;
  localparam int unsigned ST_STOV  = 1;

  typedef enum logic {
    OUT_ON_DD = 1'b0,
    OUT_ON_DU = 1'b1
  } port_sel_e;
endpackage

// File: rtl/tdm_frame_pos.sv
module tdm_frame_pos #(
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned BW     = 8,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              fsc_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              start_o,
  output logic [SLOT_W-1:0] start_slot_o
);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BW - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic              valid_q, valid_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;

  always_comb begin
    valid_d = valid_q;
    slot_d  = slot_q;
    bit_d   = bit_q;
    if (bit_en_i) begin
      if (fsc_i) begin
        valid_d = 1'b1;
        slot_d  = '0;
        bit_d   = '0;
      end else if (valid_q) begin
        if (bit_q == LAST_BIT) begin
          bit_d  = '0;
          slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      bit_q   <= '0;
    end else begin
      valid_q <= valid_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
    end
  end

  assign valid_o      = valid_q;
  assign slot_o       = slot_q;
  assign bit_o        = bit_q;
  // strobe that opens bit 0 of a slot
  assign start_o      = bit_en_i && valid_d && (bit_d == '0);
  assign start_slot_o = slot_d;
endmodule

// File: rtl/tdm_access_chan.sv
module tdm_access_chan
  import tdm_access_pkg::*;
#(
  parameter int unsigned BW     = 8,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned BIT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] start_slot_i,
  input  logic [SLOT_W-1:0] ts_i,
  input  logic              dps_i,
  input  logic              en_in_i,
  input  logic              en_out_i,
  input  logic              line_dd_i,
  input  logic              line_du_i,
  input  logic [BW-1:0]     data_i,
  output logic              pass_o,
  output logic              cap_o,
  output logic [BW-1:0]     cap_byte_o,
  output logic              drv_dd_o,
  output logic              drv_du_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BW - 1);

  logic [BW-1:0] sh_q;
  logic [BW-1:0] hold_q;
  logic          hit, in_bit, out_bit, active;
  port_sel_e     psel;

  assign psel    = port_sel_e'(dps_i);
  assign hit     = valid_i && (slot_i == ts_i);
  assign in_bit  = (psel == OUT_ON_DD) ? line_du_i : line_dd_i;
  assign pass_o  = bit_en_i && hit && (bit_i == LAST_BIT);
  assign cap_o   = pass_o && en_in_i;
  assign cap_byte_o = {sh_q[BW-2:0], in_bit};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '1;
    end else if (bit_en_i && hit) begin
      sh_q <= {sh_q[BW-2:0], in_bit};
    end
  end

  // output byte frozen at slot start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '1;
    end else if (start_i && (start_slot_i == ts_i)) begin
      hold_q <= data_i;
    end
  end

  assign out_bit  = hold_q[LAST_BIT - bit_i];
  assign active   = hit && en_out_i;
  assign drv_dd_o = (active && psel == OUT_ON_DD) ? out_bit : 1'b1;
  assign drv_du_o = (active && psel == OUT_ON_DU) ? out_bit : 1'b1;
endmodule

// File: rtl/tdm_sync_irq.sv
module tdm_sync_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_sti_i,
  input  logic clr_stov_i,
  output logic sti_o,
  output logic stov_o
);
  logic sti_q, stov_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sti_q  <= 1'b0;
      stov_q <= 1'b0;
    end else begin
      sti_q  <= (sti_q && !clr_sti_i) || evt_i;
      stov_q <= (stov_q && !clr_stov_i) || (evt_i && sti_q);
    end
  end

  assign sti_o  = sti_q;
  assign stov_o = stov_q;
endmodule

// File: rtl/tdm_slot_access.sv
module tdm_slot_access
  import tdm_access_pkg::*;
#(
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned BW     = 8,
  parameter int unsigned PAIRS  = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              fsc_i,
  input  logic              dd_i,
  input  logic              du_i,
  output logic              dd_o,
  output logic              du_o,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BW-1:0]     wdata_i,
  output logic [BW-1:0]     rdata_o,
  output logic              irq_o
);
  localparam int unsigned NCH    = 2 * PAIRS;
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned BIT_W  = $clog2(BW);
  localparam int unsigned CH_W   = $clog2(NCH);
  localparam logic [ADDR_W-1:0] A_SWAP = ADDR_W'(2 * NCH);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NCH + 1);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(2 * NCH + 2);

  logic              pos_valid;
  logic [SLOT_W-1:0] cur_slot;
  logic [BIT_W-1:0]  cur_bit;
  logic              slot_start;
  logic [SLOT_W-1:0] start_slot;

  logic [BW-1:0] data_q [NCH];
  logic [BW-1:0] cfg_q  [NCH];
  logic [BW-1:0] cap_byte [NCH];
  logic [BW-1:0] cap_val  [NCH];
  logic [BW-1:0] swap_q, sel_q;
  logic [NCH-1:0] pass, cap, cap_hit, drv_dd, drv_du;
  logic sti, stov, watch_evt, clr_sti, clr_stov;

  tdm_frame_pos #(
    .SLOTS(SLOTS), .BW(BW), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
  ) u_pos (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .fsc_i       (fsc_i),
    .valid_o     (pos_valid),
    .slot_o      (cur_slot),
    .bit_o       (cur_bit),
    .start_o     (slot_start),
    .start_slot_o(start_slot)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int unsigned PARTNER = i ^ 1;

    tdm_access_chan #(
      .BW(BW), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
    ) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .bit_en_i    (bit_en_i),
      .valid_i     (pos_valid),
      .slot_i      (cur_slot),
      .bit_i       (cur_bit),
      .start_i     (slot_start),
      .start_slot_i(start_slot),
      .ts_i        (cfg_q[i][SLOT_W-1:0]),
      .dps_i       (cfg_q[i][CFG_DPS]),
      .en_in_i     (cfg_q[i][CFG_EIN]),
      .en_out_i    (cfg_q[i][CFG_EOUT]),
      .line_dd_i   (dd_i),
      .line_du_i   (du_i),
      .data_i      (data_q[i]),
      .pass_o      (pass[i]),
      .cap_o       (cap[i]),
      .cap_byte_o  (cap_byte[i]),
      .drv_dd_o    (drv_dd[i]),
      .drv_du_o    (drv_du[i])
    );

    // swap cross-connects capture paths within the pair
    assign cap_hit[i] = swap_q[i/2] ? cap[PARTNER] : cap[i];
    assign cap_val[i] = swap_q[i/2] ? cap_byte[PARTNER] : cap_byte[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[i] <= '1;
      end else if (cap_hit[i]) begin
        data_q[i] <= cap_val[i];
      end else if (wr_i && addr_i == ADDR_W'(i)) begin
        data_q[i] <= wdata_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
      end else if (wr_i && addr_i == ADDR_W'(NCH + i)) begin
        cfg_q[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      swap_q <= '0;
      sel_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_SWAP) swap_q <= wdata_i;
      if (addr_i == A_SEL)  sel_q  <= wdata_i;
    end
  end

  assign watch_evt = sel_q[CH_W] && pass[sel_q[CH_W-1:0]];
  assign clr_sti   = wr_i && (addr_i == A_STAT) && wdata_i[ST_STI];
  assign clr_stov  = wr_i && (addr_i == A_STAT) && wdata_i[ST_STOV];

  tdm_sync_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (watch_evt),
    .clr_sti_i (clr_sti),
    .clr_stov_i(clr_stov),
    .sti_o     (sti),
    .stov_o    (stov)
  );

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(i))       rdata_o = data_q[i];
      if (addr_i == ADDR_W'(NCH + i)) rdata_o = cfg_q[i];
    end
    if (addr_i == A_SWAP) rdata_o = swap_q;
    if (addr_i == A_STAT) rdata_o = {{(BW-2){1'b0}}, stov, sti};
    if (addr_i == A_SEL)  rdata_o = sel_q;
  end

  assign dd_o  = &drv_dd;
  assign du_o  = &drv_du;
  assign irq_o = sti || stov;
endmodule

// File: rtl/tdm_slot_access_chk.sv
module tdm_slot_access_chk #(
  parameter int unsigned SLOTS  = 12,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned BIT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bit_en_i,
  input logic              fsc_i,
  input logic              dd_o,
  input logic              du_o,
  input logic              valid_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [BIT_W-1:0]  bit_i,
  input logic              sti_i,
  input logic              stov_i
);
  a_r2_quiet_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (dd_o && du_o));

  a_r2_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && fsc_i) |=> (valid_i && slot_i == '0 && bit_i == '0));

  a_r2_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> ($stable(slot_i) && $stable(bit_i)));

  a_r2_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (slot_i < SLOT_W'(SLOTS)));

  a_r9_sti_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sti_i) |-> $past(bit_en_i));

  a_r10_stov_needs_sti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stov_i) |-> $past(sti_i));
endmodule

bind tdm_slot_access tdm_slot_access_chk #(
  .SLOTS(SLOTS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .bit_en_i(bit_en_i),
  .fsc_i   (fsc_i),
  .dd_o    (dd_o),
  .du_o    (du_o),
  .valid_i (pos_valid),
  .slot_i  (cur_slot),
  .bit_i   (cur_bit),
  .sti_i   (sti),
  .stov_i  (stov)
);

// File: tb/tdm_slot_access_bench.sv
module tdm_slot_access_bench;
  logic       clk_i = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0, fsc = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ext_dd_b = 1'b1, ext_du_b = 1'b1;
  logic       dd_o, du_o, irq;
  logic [7:0] rdata;
  logic       dd_line, du_line;

  assign dd_line = ext_dd_b & dd_o;
  assign du_line = ext_du_b & du_o;

  always #2 clk_i = ~clk_i;

  tdm_slot_access u_tdm_slot_access (
    .clk_i(clk_i), .rst_ni(rst_n), .bit_en_i(bit_en), .fsc_i(fsc),
    .dd_i(dd_line), .du_i(du_line), .dd_o(dd_o), .du_o(du_o),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, wd = 0, cyc = 0;
  bit running = 0;
  int ext_dd[12], ext_du[12];
  logic [7:0] obs_dd[8][12], obs_du[8][12];
  int pend_wr = 0, pend_a, pend_d;
  int arm_pos = -1, arm_a, arm_d;

  // behavioural reference model
  int m_data[4], m_cfg[4], m_hold[4], m_sh[4];
  int m_swap, m_sel, m_pos, m_frame, m_sti, m_stov;

  function automatic int f_ts(int c);  return m_cfg[c] & 15; endfunction
  function automatic int f_dps(int c); return (m_cfg[c] >> 4) & 1; endfunction
  function automatic int f_ein(int c); return (m_cfg[c] >> 5) & 1; endfunction
  function automatic int f_eout(int c); return (m_cfg[c] >> 6) & 1; endfunction

  function automatic int mdrv(int lsel);
    int v = 1;
    if (m_pos >= 0)
      for (int c = 0; c < 4; c++)
        if (f_eout(c) == 1 && f_ts(c) == m_pos / 8 && f_dps(c) == lsel)
          v &= (m_hold[c] >> (7 - m_pos % 8)) & 1;
    return v;
  endfunction

  function automatic int mread(int a);
    if (a < 4) return m_data[a];
    if (a < 8) return m_cfg[a-4];
    if (a == 8) return m_swap;
    if (a == 9) return (m_stov << 1) | m_sti;
    if (a == 10) return m_sel;
    return 0;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      m_data[c] = 255; m_cfg[c] = 0; m_hold[c] = 255; m_sh[c] = 255;
    end
    m_swap = 0; m_sel = 0; m_pos = -1; m_frame = -1; m_sti = 0; m_stov = 0;
  endtask

  task automatic model_step();
    int ddl, dul, np, ev, old_sti, s;
    int pass[4], capv[4], caught[4];
    ddl = int'(ext_dd_b) & mdrv(0);
    dul = int'(ext_du_b) & mdrv(1);
    ev = 0;
    for (int c = 0; c < 4; c++) begin pass[c] = 0; capv[c] = 0; caught[c] = 0; end
    if (bit_en && m_pos >= 0) begin
      for (int c = 0; c < 4; c++)
        if (f_ts(c) == m_pos / 8) begin
          m_sh[c] = ((m_sh[c] << 1) | (f_dps(c) == 1 ? ddl : dul)) & 255;
          if (m_pos % 8 == 7) begin pass[c] = 1; capv[c] = m_sh[c]; end
        end
      if (((m_sel >> 2) & 1) == 1) ev = pass[m_sel & 3];
    end
    np = m_pos;
    if (bit_en) begin
      if (fsc) begin
        np = 0;
        m_frame = (m_pos >= 0) ? m_frame + 1 : 0;
      end else if (m_pos >= 0) np = (m_pos + 1) % 96;
    end
    if (bit_en && np >= 0 && np % 8 == 0)
      for (int c = 0; c < 4; c++) if (f_ts(c) == np / 8) m_hold[c] = m_data[c];
    for (int t = 0; t < 4; t++) begin
      s = (((m_swap >> (t / 2)) & 1) == 1) ? (t ^ 1) : t;
      if (pass[s] == 1 && f_ein(s) == 1) begin m_data[t] = capv[s]; caught[t] = 1; end
    end
    old_sti = m_sti;
    if (wr) begin
      if (addr < 4) begin
        if (caught[addr] == 0) m_data[addr] = wdata;
      end else if (addr < 8) m_cfg[addr-4] = wdata;
      else if (addr == 8) m_swap = wdata;
      else if (addr == 9) begin
        if (wdata[0]) m_sti = 0;
        if (wdata[1]) m_stov = 0;
      end else if (addr == 10) m_sel = wdata;
    end
    if (ev == 1) begin
      m_sti = 1;
      if (old_sti == 1) m_stov = 1;
    end
    m_pos = np;
  endtask

  always @(posedge clk_i) if (rst_n) model_step();

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected=<150000", wd);
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk_i);
    chk("R4 dd drive vs model", int'(dd_o), mdrv(0));
    chk("R3 du drive vs model", int'(du_o), mdrv(1));
    chk("R9 irq vs model", int'(irq), (m_sti | m_stov));
    chk("R12 rdata vs model", int'(rdata), mread(int'(addr)));
    if (m_pos >= 0 && m_frame >= 0 && m_frame < 8) begin
      obs_dd[m_frame][m_pos/8][7 - m_pos%8] = dd_o;
      obs_du[m_frame][m_pos/8][7 - m_pos%8] = du_o;
    end
    cyc++;
    bit_en = running && (cyc % 2 == 1);
    fsc = bit_en && (m_pos < 0 || m_pos == 95);
    ext_dd_b = (m_pos >= 0) ? ext_dd[m_pos/8][7 - m_pos%8] : 1'b1;
    ext_du_b = (m_pos >= 0) ? ext_du[m_pos/8][7 - m_pos%8] : 1'b1;
    wr = 1'b0;
    if (pend_wr == 1) begin
      wr = 1'b1; addr = 4'(pend_a); wdata = 8'(pend_d); pend_wr = 0;
    end else if (arm_pos >= 0 && bit_en && m_pos == arm_pos) begin
      wr = 1'b1; addr = 4'(arm_a); wdata = 8'(arm_d); arm_pos = -1;
    end
  endtask

  task automatic wr_reg(int a, int d);
    pend_wr = 1; pend_a = a; pend_d = d;
    tick();
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    tick();
    addr = 4'(a);
    #1;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic run_to(int f, int slot);
    running = 1;
    while (!(m_frame == f && m_pos == slot * 8)) tick();
  endtask

  task automatic do_reset();
    running = 0; bit_en = 0; fsc = 0; wr = 0; addr = '0; arm_pos = -1;
    rst_n = 1'b0;
    model_reset();
    for (int s = 0; s < 12; s++) begin ext_dd[s] = 255; ext_du[s] = 255; end
    for (int f = 0; f < 8; f++)
      for (int s = 0; s < 12; s++) begin obs_dd[f][s] = 8'hFF; obs_du[f][s] = 8'hFF; end
    repeat (3) @(negedge clk_i);
    rst_n = 1'b1;
  endtask

  initial begin
    // reset state
    do_reset();
    #1;
    chk("R1 dd idle", int'(dd_o), 1);
    chk("R1 du idle", int'(du_o), 1);
    chk("R1 irq low", int'(irq), 0);
    rd_chk(0, 8'hFF, "R1 data reset");
    rd_chk(5, 0, "R1 cfg reset");
    rd_chk(9, 0, "R1 status reset");
    rd_chk(13, 0, "R12 unmapped reads zero");

    // looping slot 3 DU -> DD
    do_reset();
    ext_du[3] = 8'hA5;
    wr_reg(4, 8'h63);
    run_to(2, 0);
    chk("R5 loop frame0 not yet", int'(obs_dd[0][3]), 8'hFF);
    chk("R5 loop frame1 replay", int'(obs_dd[1][3]), 8'hA5);
    rd_chk(0, 8'hA5, "R3 captured from DU");

    // shift 2 -> 4 same frame via swap
    do_reset();
    ext_du[2] = 8'h3C;
    wr_reg(8, 1);
    wr_reg(4, 8'h22);
    wr_reg(5, 8'h44);
    run_to(1, 0);
    chk("R6 shift b=a+2 same frame", int'(obs_dd[0][4]), 8'h3C);
    rd_chk(1, 8'h3C, "R7 partner receives");
    rd_chk(0, 8'hFF, "R7 own register untouched");

    // shift 5 -> 6 next frame
    do_reset();
    ext_du[5] = 8'hC3;
    wr_reg(8, 1);
    wr_reg(4, 8'h25);
    wr_reg(5, 8'h46);
    run_to(2, 0);
    chk("R6 shift b=a+1 frame0 idle", int'(obs_dd[0][6]), 8'hFF);
    chk("R6 shift b=a+1 frame1", int'(obs_dd[1][6]), 8'hC3);

    // shift 7 -> 1 backwards
    do_reset();
    ext_du[7] = 8'h5A;
    wr_reg(8, 1);
    wr_reg(4, 8'h27);
    wr_reg(5, 8'h41);
    run_to(2, 0);
    chk("R6 shift b<a frame0 idle", int'(obs_dd[0][1]), 8'hFF);
    chk("R6 shift b<a frame1", int'(obs_dd[1][1]), 8'h5A);

    // monitor, DU output, wired-AND
    do_reset();
    ext_dd[9] = 8'h5E;
    wr_reg(0, 8'hF0);
    wr_reg(1, 8'h3C);
    wr_reg(3, 8'h81);
    wr_reg(4, 8'h4A);
    wr_reg(5, 8'h4A);
    wr_reg(6, 8'h39);
    wr_reg(7, 8'h57);
    run_to(1, 0);
    chk("R4 wired-AND two drivers", int'(obs_dd[0][10]), 8'h30);
    chk("R3 dps1 drives DU", int'(obs_du[0][7]), 8'h81);
    chk("R3 dps1 leaves DD", int'(obs_dd[0][7]), 8'hFF);
    chk("R8 monitor does not drive", int'(obs_dd[0][9]), 8'hFF);
    rd_chk(6, 8'h39, "R12 cfg readback");
    rd_chk(2, 8'h5E, "R8 monitored byte");
    rd_chk(3, 8'h81, "R4 no capture without enable");

    // transfer / overflow flags
    do_reset();
    wr_reg(10, 8'h04);
    wr_reg(4, 8'h01);
    run_to(0, 3);
    rd_chk(9, 1, "R9 transfer flag set");
    chk("R9 irq raised", int'(irq), 1);
    run_to(1, 3);
    rd_chk(9, 3, "R10 overflow without ack");
    wr_reg(9, 3);
    rd_chk(9, 0, "R9 flags cleared");
    run_to(2, 3);
    wr_reg(9, 1);
    rd_chk(9, 0, "R9 ack clears");
    run_to(3, 3);
    rd_chk(9, 1, "R10 acked window no overflow");

    // capture vs host write on same edge
    do_reset();
    ext_du[4] = 8'h99;
    wr_reg(4, 8'h24);
    arm_pos = 39; arm_a = 0; arm_d = 8'h11;
    run_to(0, 6);
    chk("R11 write was issued", arm_pos, -1);
    rd_chk(0, 8'h99, "R11 capture wins");
    wr_reg(0, 8'h22);
    rd_chk(0, 8'h22, "R12 host write lands");

    summary();
    $finish;
  end
endmodule